// File: doc/BRIEF.md
# Wide Flat Smoothing Filter

This block smooths one line of sixteen 8-bit pixels that lies across a block edge. The pixels are numbered from the near side outward-in: p7 (far left) through p0, then q0 through q7 (far right). When the line is marked for wide smoothing, every inner position p6 through q6 is replaced by a rounded 16-sample weighted average centred on that position. Samples that would fall past either end of the line are taken as the end pixel (p7 or q7). When the line is not marked, each inner position passes through unchanged. The end pixels p7 and q7 are never produced as outputs.

A whole line enters in one transfer on a valid/ready input. The block then emits the fourteen results one per transfer on a valid/ready output, each tagged with its index, and pulses a done flag once the last result has been taken. A single accumulator holds the window sum. It starts from a closed-form sum for p6 and slides one position per output by adding two samples and removing two. This replaces fourteen separate adder trees.

Back-pressure: an input line transfers only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low from acceptance until the last output has been taken. An output transfers on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the output value and index hold steady.

Top module: `wide_flat_smoother`

## Requirements
- R1: After reset `out_valid` and `done` are 0 and `in_ready` is 1.
- R2: `in_ready` is 0 while a line is being emitted; a line offered in that time is not taken and does not change any output.
- R3: Each accepted line produces exactly 14 outputs with `out_idx` 0,1,…,13 in order (0 = p6, 13 = q6). `out_last` is 1 only on index 13.
- R4: With wide select set, the output for pixel position i (p7 = 0 … q7 = 15, index = i−1) is (S+8)>>4. S is the sum of pixel[clamp(j)] for j = i−7 … i+7, plus pixel[i] once more. clamp() limits the position to 0…15.
- R5: With wide select set, the first output is (7·p7 + 2·p6 + p5 + p4 + p3 + p2 + p1 + p0 + q0 + 8)>>4.
- R6: With wide select clear, the output at index k equals input pixel position k+1 unchanged.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with `out_pix` and `out_idx` unchanged.
- R8: `done` is 1 for exactly one cycle, the cycle after the index-13 output transfers, and at no other time.
- R9: A line of sixteen equal pixels with wide select set yields fourteen outputs equal to that pixel value.
- R10: With wide select set, the last output is (p0 + q0 + q1 + q2 + q3 + q4 + q5 + 2·q6 + 7·q7 + 8)>>4, so q7 is counted for every position past the line's end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input line offered |
| in_ready | output | 1 | Block can take a line |
| in_line | input | 128 | Sixteen pixels; bits [8k+7:8k] hold position k (0 = p7, 15 = q7) |
| in_wide | input | 1 | Apply wide smoothing to this line |
| out_valid | output | 1 | Output pixel available |
| out_ready | input | 1 | Consumer takes the output |
| out_pix | output | 8 | Output pixel value |
| out_idx | output | 4 | Output index, 0 = p6 … 13 = q6 |
| out_last | output | 1 | Current output is q6 |
| done | output | 1 | One-cycle pulse after the final output transfers |

## Verification
The checker watches the handshake rules on every cycle. It checks that output payload holds under back-pressure, that the index steps by one per transfer, and that the first index follows acceptance. It also checks that the done pulse pairs with the final transfer and that `in_ready` stays low during emission. The arithmetic can only be shown by the bench's scenarios: the sliding window sum, the edge replication at both ends, and the pass-through when wide select is clear. Those scenarios compare every output with a direct per-position sum over flat, random, saturated and step lines, under both steady and random back-pressure.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  typedef enum logic {WFS_IDLE = 1'b0, WFS_EMIT = 1'b1} wfs_state_e;

  function automatic int wfs_clamp(input int j, input int n);
    if (j < 0) return 0;
    if (j > n - 1) return n - 1;
    return j;
  endfunction
endpackage

// File: rtl/wfs_init_sum.sv
module wfs_init_sum #(
  parameter int PIX_W = 8,
  parameter int TAPS  = 16,
  parameter int ACC_W = 12
) (
  input  logic [TAPS*PIX_W-1:0] line_i,
  output logic [ACC_W-1:0]      sum_o
);
  localparam int HALF = TAPS / 2;

  logic [PIX_W-1:0] px [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_unpack
    assign px[k] = line_i[k*PIX_W +: PIX_W];
  end

  // Window for position 1: positions 2-HALF .. HALF, clamped low, plus centre again.
  always_comb begin
    sum_o = ACC_W'(px[1]);
    for (int j = 2 - HALF; j <= HALF; j++) begin
      sum_o = sum_o + ACC_W'(px[wfs_pkg::wfs_clamp(j, TAPS)]);
    end
  end
endmodule

// File: rtl/wfs_slide_delta.sv
module wfs_slide_delta #(
  parameter int PIX_W   = 8,
  parameter int TAPS    = 16,
  parameter int IDX_W   = 4,
  parameter int DELTA_W = 10
) (
  input  logic [TAPS*PIX_W-1:0]     line_i,
  input  logic [IDX_W-1:0]          pos_i,
  output logic signed [DELTA_W-1:0] delta_o
);
  localparam int HALF = TAPS / 2;

  logic [PIX_W-1:0] px [TAPS];
  logic [DELTA_W-1:0] gain, loss;

  for (genvar k = 0; k < TAPS; k++) begin : g_unpack
    assign px[k] = line_i[k*PIX_W +: PIX_W];
  end

  // Step pos -> pos+1: gain next centre and next far-side sample,
  // lose current centre and oldest window sample.
  always_comb begin
    int p;
    int far_i, old_i, nxt_i;
    p     = int'(pos_i);
    far_i = wfs_pkg::wfs_clamp(p + HALF, TAPS);
    old_i = wfs_pkg::wfs_clamp(p + 1 - HALF, TAPS);
    nxt_i = wfs_pkg::wfs_clamp(p + 1, TAPS);
    gain  = DELTA_W'(px[far_i]) + DELTA_W'(px[nxt_i]);
    loss  = DELTA_W'(px[old_i]) + DELTA_W'(px[wfs_pkg::wfs_clamp(p, TAPS)]);
    delta_o = $signed(gain) - $signed(loss);
  end
endmodule

// File: rtl/wfs_round_sel.sv
module wfs_round_sel #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 12,
  parameter int SHIFT = 4
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             wide_i,
  input  logic [PIX_W-1:0] orig_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (SHIFT - 1);

  logic [ACC_W-1:0] rounded;

  always_comb begin
    rounded = (acc_i + HALF_LSB) >> SHIFT;
    pix_o   = wide_i ? rounded[PIX_W-1:0] : orig_i;
  end
endmodule

// File: rtl/wide_flat_smoother.sv
module wide_flat_smoother #(
  parameter int PIX_W = 8,
  parameter int TAPS  = 16,
  parameter int IDX_W = $clog2(TAPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [TAPS*PIX_W-1:0] in_line,
  input  logic                  in_wide,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [PIX_W-1:0]      out_pix,
  output logic [IDX_W-1:0]      out_idx,
  output logic                  out_last,
  output logic                  done
);
  import wfs_pkg::*;

  localparam int SHIFT   = $clog2(TAPS);
  localparam int ACC_W   = PIX_W + SHIFT;
  localparam int DELTA_W = PIX_W + 2;
  localparam logic [IDX_W-1:0] POS_FIRST = IDX_W'(1);
  localparam logic [IDX_W-1:0] POS_LAST  = IDX_W'(TAPS - 2);

  wfs_state_e              state_q;
  logic [IDX_W-1:0]        pos_q;
  logic [ACC_W-1:0]        acc_q;
  logic [TAPS*PIX_W-1:0]   line_q;
  logic                    wide_q;
  logic                    done_q;

  logic [ACC_W-1:0]          init_sum;
  logic signed [DELTA_W-1:0] delta;
  logic [ACC_W-1:0]          delta_ext;
  logic [PIX_W-1:0]          orig_pix;
  logic                      accept, fire, at_last;

  wfs_init_sum #(.PIX_W(PIX_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_init (
    .line_i (in_line),
    .sum_o  (init_sum)
  );

  wfs_slide_delta #(.PIX_W(PIX_W), .TAPS(TAPS), .IDX_W(IDX_W), .DELTA_W(DELTA_W)) u_delta (
    .line_i  (line_q),
    .pos_i   (pos_q),
    .delta_o (delta)
  );

  assign orig_pix = line_q[pos_q*PIX_W +: PIX_W];

  wfs_round_sel #(.PIX_W(PIX_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_round (
    .acc_i  (acc_q),
    .wide_i (wide_q),
    .orig_i (orig_pix),
    .pix_o  (out_pix)
  );

  assign in_ready  = (state_q == WFS_IDLE);
  assign out_valid = (state_q == WFS_EMIT);
  assign at_last   = (pos_q == POS_LAST);
  assign out_last  = out_valid && at_last;
  assign out_idx   = pos_q - POS_FIRST;
  assign accept    = in_valid && in_ready;
  assign fire      = out_valid && out_ready;
  assign delta_ext = {{(ACC_W-DELTA_W){delta[DELTA_W-1]}}, delta};
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WFS_IDLE;
      pos_q   <= POS_FIRST;
      acc_q   <= '0;
      line_q  <= '0;
      wide_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire && at_last;
      if (accept) begin
        state_q <= WFS_EMIT;
        pos_q   <= POS_FIRST;
        acc_q   <= init_sum;
        line_q  <= in_line;
        wide_q  <= in_wide;
      end else if (fire) begin
        if (at_last) begin
          state_q <= WFS_IDLE;
        end else begin
          pos_q <= pos_q + IDX_W'(1);
          acc_q <= acc_q + delta_ext;
        end
      end
    end
  end
endmodule

// File: rtl/wfs_checker.sv
module wfs_checker #(
  parameter int PIX_W = 8,
  parameter int TAPS  = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix,
  input logic [IDX_W-1:0] out_idx,
  input logic             out_last,
  input logic             done
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(TAPS - 3);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2

  AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_idx == '0)); // R3

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && out_idx == $past(out_idx) + IDX_W'(1))); // R3

  AST_LAST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_idx == IDX_END)); // R3

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_idx))); // R7

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> done); // R8

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready && out_last)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

bind wide_flat_smoother wfs_checker #(.PIX_W(PIX_W), .TAPS(TAPS), .IDX_W(IDX_W)) u_wfs_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix),
  .out_idx   (out_idx),
  .out_last  (out_last),
  .done      (done)
);

// File: tb/tb_wide_flat_smoother.sv
module tb_wide_flat_smoother;
  localparam int PIX_W = 8;
  localparam int TAPS  = 16;
  localparam int IDX_W = 4;

  typedef struct {
    logic [7:0] pix;
    int         idx;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [TAPS*PIX_W-1:0] in_line = '0;
  logic in_wide = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [PIX_W-1:0] out_pix;
  logic [IDX_W-1:0] out_idx;
  logic out_last;
  logic done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit rand_ready = 0;
  bit expect_done = 0;
  bit stall_seen = 0;
  logic [7:0] stall_pix;
  int stall_idx;
  logic [15:0] lfsr = 16'hACE1;
  exp_t sb[$];

  always #2 clk = ~clk;

  wide_flat_smoother #(.PIX_W(PIX_W), .TAPS(TAPS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_line(in_line), .in_wide(in_wide), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix), .out_idx(out_idx),
    .out_last(out_last), .done(done)
  );

  function automatic int px(input logic [TAPS*PIX_W-1:0] l, input int j);
    int c;
    c = (j < 0) ? 0 : ((j > TAPS - 1) ? TAPS - 1 : j);
    return int'(l[c*PIX_W +: PIX_W]);
  endfunction

  function automatic logic [7:0] exp_pix(input logic [TAPS*PIX_W-1:0] l, input bit wide, input int k);
    int s;
    int i;
    i = k + 1;
    if (!wide) return 8'(px(l, i));
    if (k == 0)       // R5 closed form
      s = 7*px(l,0) + 2*px(l,1) + px(l,2) + px(l,3) + px(l,4) + px(l,5) + px(l,6) + px(l,7) + px(l,8);
    else if (k == 13) // R10 closed form
      s = px(l,7) + px(l,8) + px(l,9) + px(l,10) + px(l,11) + px(l,12) + px(l,13) + 2*px(l,14) + 7*px(l,15);
    else begin        // R4 direct window sum
      s = px(l, i);
      for (int j = i - 7; j <= i + 7; j++) s += px(l, j);
    end
    return 8'((s + 8) >> 4);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send_line(input logic [TAPS*PIX_W-1:0] l, input bit wide, input string tag);
    for (int k = 0; k < 14; k++) begin
      exp_t e;
      e.pix = exp_pix(l, wide, k);
      e.idx = k;
      e.tag = !wide ? "R6" : (tag != "") ? tag : (k == 0) ? "R5" : (k == 13) ? "R10" : "R4";
      sb.push_back(e);
    end
    @(negedge clk);
    in_line  = l;
    in_wide  = wide;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (sb.size() != 0 || !in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [TAPS*PIX_W-1:0] rnd_line();
    logic [TAPS*PIX_W-1:0] l;
    for (int k = 0; k < TAPS; k++) l[k*PIX_W +: PIX_W] = 8'($urandom_range(0, 255));
    return l;
  endfunction

  // Monitor / scoreboard: inputs change at negedge, handshake resolved for next posedge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (expect_done) check(done === 1'b1, "R8", int'(done), 1);
      else if (done !== 1'b0) check(1'b0, "R8", int'(done), 0);
      expect_done = 0;
      if (stall_seen) begin
        check(out_valid === 1'b1 && out_pix === stall_pix && int'(out_idx) == stall_idx,
              "R7", int'(out_pix), int'(stall_pix));
        stall_seen = 0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = rand_ready ? lfsr[0] : 1'b1;
      #1;
      if (out_valid) begin
        check(in_ready === 1'b0, "R2", int'(in_ready), 0);
        if (out_ready) begin
          if (sb.size() == 0) check(1'b0, "R3", int'(out_idx), -1);
          else begin
            exp_t e;
            e = sb.pop_front();
            check(int'(out_idx) == e.idx, "R3", int'(out_idx), e.idx);
            check(out_last === (e.idx == 13), "R3", int'(out_last), int'(e.idx == 13));
            check(out_pix === e.pix, e.tag, int'(out_pix), int'(e.pix));
            if (e.idx == 13) expect_done = 1;
          end
        end else begin
          stall_seen = 1;
          stall_pix  = out_pix;
          stall_idx  = int'(out_idx);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    logic [TAPS*PIX_W-1:0] l;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid === 1'b0, "R1", int'(out_valid), 0);
    check(done === 1'b0, "R1", int'(done), 0);
    check(in_ready === 1'b1, "R1", int'(in_ready), 1);

    // R9 flat lines
    send_line({TAPS{8'd77}}, 1'b1, "R9");
    wait_idle();
    send_line({TAPS{8'd255}}, 1'b1, "R9");
    wait_idle();

    // R4 R5 R10 random lines, steady ready
    for (int n = 0; n < 6; n++) begin
      send_line(rnd_line(), 1'b1, "");
    end
    wait_idle();

    // R10 step: p side 0, q side 255
    l = '0;
    for (int k = 8; k < TAPS; k++) l[k*PIX_W +: PIX_W] = 8'd255;
    send_line(l, 1'b1, "");
    wait_idle();

    // R6 pass-through
    for (int n = 0; n < 3; n++) send_line(rnd_line(), 1'b0, "");
    wait_idle();

    // R7 random back-pressure
    rand_ready = 1;
    for (int n = 0; n < 10; n++) send_line(rnd_line(), n[0], "");
    wait_idle();
    rand_ready = 0;

    // R2 line offered while busy is not taken
    send_line({TAPS{8'd10}}, 1'b1, "R2");
    @(negedge clk);
    in_line  = {TAPS{8'd200}};
    in_wide  = 1'b0;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    wait_idle();
    #1;
    check(out_valid === 1'b0, "R2", int'(out_valid), 0);

    finish_run();
  end
endmodule